// File: doc/BRIEF.md
# Dual Data Cache Allocation Controller

This block sits between a processor's load/store port and a word-wide external memory port. It keeps two set-associative data stores: a larger main cache and a smaller minicache. Every access carries two attribute bits, cacheable and bufferable. A lookup checks both stores at once. A hit is served by whichever store holds the line, and the attribute bits play no part in that. On a load miss the attribute pair picks where the line goes: the minicache, the main cache, or nowhere. If the line goes nowhere, the controller does one uncached word read.

Stores never allocate. A store hit updates the line and marks it dirty. A store miss becomes one external word write, and that write carries the access's bufferable bit. When the victim line chosen for a fill is dirty, the controller first writes the whole victim line out as bufferable writes, then fetches the new line. Each store picks its victim per set in round-robin order.

The memory port is a request/acknowledge handshake. The controller holds one word request until a one-cycle acknowledge arrives. The words of a line move in ascending order from the line base.

Top module: `dcc_top`

## Requirements
- R1: An access that hits either store is answered with `rsp_valid` in the first cycle after acceptance, makes no memory request, and behaves the same for all four cacheable/bufferable combinations.
- R2: A load miss with cacheable=0 makes exactly one memory read at the access address and allocates nothing, so repeating it misses again.
- R3: A load miss with cacheable=1 and bufferable=0 fills the line into the minicache, and later accesses to that line hit.
- R4: A load miss with cacheable=1 and bufferable=1 fills the line into the main cache, and later accesses to that line hit.
- R5: A line fill is 8 word reads at byte offsets 0,4,...,28 from the 32-byte line base, in that order. Each request is held stable until its acknowledge. The load returns the requested word.
- R6: Each store has a victim pointer per set. It starts at way 0 after reset and advances (wrapping) only when that set allocates. Byte address bits [6:5] select the main set (4 sets, 2 ways). Bit [5] selects the minicache set (2 sets, 2 ways).
- R7: A store hit writes the word into the hitting line and marks it dirty without memory traffic. A later load of that word returns the stored data.
- R8: A store miss makes one memory write at the access address with `mem_bufferable` equal to the access's bufferable bit (1 = bufferable), and allocates nothing.
- R9: When the victim of a fill is dirty, its 8 words are written to memory with `mem_bufferable`=1, all before the first fill read. Memory then holds the evicted data.
- R10: With `cache_en` low, nothing hits and nothing allocates: every load is one memory read and every store is one memory write.
- R11: Reset leaves `req_ready`=1, `mem_req`=0, `rsp_valid`=0, and every line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; low makes all accesses uncached |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_cacheable | input | 1 | Cacheable attribute |
| req_bufferable | input | 1 | Bufferable attribute |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data (0 for stores) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_bufferable | output | 1 | Write may be buffered |
| mem_ack | input | 1 | One-cycle acknowledge of the held request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
A hit produces its response at the clock edge that accepts it, so `rsp_valid` is due at the first falling edge after acceptance. Every miss finishes one edge after the final memory acknowledge. The bench drives and samples only on falling edges. For each access it waits a bounded number of falling edges for the response pulse, and it requires a latency of exactly one for hits. The memory responder counts reads and writes, logs the read addresses and records the order of writes and reads. These tallies are compared with the expected traffic for each access after its response.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_RD,
        ST_WR
    } dcc_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_MINI,
        TGT_MAIN
    } dcc_target_e;

    // Allocation target of a load miss from enable and attribute bits.
    function automatic dcc_target_e pick_target(input logic en, input logic c, input logic b);
        if (!en || !c) return TGT_NONE;
        return b ? TGT_MAIN : TGT_MINI;
    endfunction

endpackage

// File: rtl/dcc_rr_ptr.sv
`timescale 1ns/1ps
module dcc_rr_ptr #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] ptr_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[s] <= '0;
            end else if (adv && set_idx == SET_W'(s)) begin
                ptr_q[s] <= (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end
    end

    assign way = ptr_q[set_idx];
endmodule

// File: rtl/dcc_cache_bank.sv
`timescale 1ns/1ps
module dcc_cache_bank #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = ADDR_W - 2 - OFF_W,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = LINE_W - SET_W,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] lk_line,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_dirty,
    output logic [LINE_W-1:0] vic_line,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic              inst_en
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic              valid_q [SETS][WAYS];
    logic              dirty_q [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    assign set_idx = lk_line[SET_W-1:0];
    assign tag_in  = lk_line[LINE_W-1:SET_W];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[set_idx][w] && tag_q[set_idx][w] == tag_in) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    dcc_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .adv     (inst_en),
        .set_idx (set_idx),
        .way     (vic_way)
    );

    assign vic_dirty = valid_q[set_idx][vic_way] && dirty_q[set_idx][vic_way];
    assign vic_line  = {tag_q[set_idx][vic_way], set_idx};
    assign rd_data   = data_q[set_idx][rd_way][rd_word];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
            end
        end else begin
            if (wr_en) begin
                data_q[set_idx][wr_way][wr_word] <= wr_data;
                if (wr_dirty) dirty_q[set_idx][wr_way] <= 1'b1;
            end
            if (inst_en) begin
                valid_q[set_idx][vic_way] <= 1'b1;
                dirty_q[set_idx][vic_way] <= 1'b0;
                tag_q[set_idx][vic_way]   <= tag_in;
            end
        end
    end
endmodule

// File: rtl/dcc_top.sv
`timescale 1ns/1ps
module dcc_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int MAIN_SETS  = 4,
    parameter int MAIN_WAYS  = 2,
    parameter int MINI_SETS  = 2,
    parameter int MINI_WAYS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic              req_bufferable,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_bufferable,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import dcc_pkg::*;

    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int LINE_W  = ADDR_W - 2 - OFF_W;
    localparam int MAIN_WW = $clog2(MAIN_WAYS);
    localparam int MINI_WW = $clog2(MINI_WAYS);

    dcc_state_e        st;
    dcc_target_e       lat_tgt;
    logic [OFF_W-1:0]  cnt;
    logic [ADDR_W-3:0] lat_word;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_b;

    logic              accept, last, hit_main, hit_mini, hit_any, in_fill;
    dcc_target_e       tgt_now;
    logic [ADDR_W-3:0] lk_word;
    logic [LINE_W-1:0] lk_line;
    logic [OFF_W-1:0]  lk_off;
    logic              unused_lsbs;

    logic               m_hit, m_vd, m_wr, m_inst;
    logic [MAIN_WW-1:0] m_hw, m_vw;
    logic [LINE_W-1:0]  m_vl;
    logic [DATA_W-1:0]  m_rd;
    logic               n_hit, n_vd, n_wr, n_inst;
    logic [MINI_WW-1:0] n_hw, n_vw;
    logic [LINE_W-1:0]  n_vl;
    logic [DATA_W-1:0]  n_rd;

    assign unused_lsbs = ^req_addr[1:0];
    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign lk_word   = (st == ST_IDLE) ? req_addr[ADDR_W-1:2] : lat_word;
    assign lk_line   = lk_word[ADDR_W-3:OFF_W];
    assign lk_off    = lk_word[OFF_W-1:0];
    assign hit_main  = cache_en && m_hit;
    assign hit_mini  = cache_en && n_hit;
    assign hit_any   = hit_main || hit_mini;
    assign tgt_now   = pick_target(cache_en, req_cacheable, req_bufferable);
    assign last      = (cnt == OFF_W'(LINE_WORDS - 1));
    assign in_fill   = (st == ST_FILL);

    // Store hits write at the request offset; fills write the victim way word by word.
    assign m_wr   = (accept && req_write && hit_main) || (in_fill && mem_ack && lat_tgt == TGT_MAIN);
    assign n_wr   = (accept && req_write && hit_mini) || (in_fill && mem_ack && lat_tgt == TGT_MINI);
    assign m_inst = in_fill && mem_ack && last && lat_tgt == TGT_MAIN;
    assign n_inst = in_fill && mem_ack && last && lat_tgt == TGT_MINI;

    dcc_cache_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
                     .SETS(MAIN_SETS), .WAYS(MAIN_WAYS)) u_main (
        .clk (clk), .rst (rst), .lk_line (lk_line),
        .hit (m_hit), .hit_way (m_hw), .vic_way (m_vw), .vic_dirty (m_vd), .vic_line (m_vl),
        .rd_way ((st == ST_WB) ? m_vw : m_hw), .rd_word ((st == ST_WB) ? cnt : lk_off), .rd_data (m_rd),
        .wr_en (m_wr), .wr_way (in_fill ? m_vw : m_hw), .wr_word (in_fill ? cnt : lk_off),
        .wr_data (in_fill ? mem_rdata : req_wdata), .wr_dirty (!in_fill), .inst_en (m_inst)
    );

    dcc_cache_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
                     .SETS(MINI_SETS), .WAYS(MINI_WAYS)) u_mini (
        .clk (clk), .rst (rst), .lk_line (lk_line),
        .hit (n_hit), .hit_way (n_hw), .vic_way (n_vw), .vic_dirty (n_vd), .vic_line (n_vl),
        .rd_way ((st == ST_WB) ? n_vw : n_hw), .rd_word ((st == ST_WB) ? cnt : lk_off), .rd_data (n_rd),
        .wr_en (n_wr), .wr_way (in_fill ? n_vw : n_hw), .wr_word (in_fill ? cnt : lk_off),
        .wr_data (in_fill ? mem_rdata : req_wdata), .wr_dirty (!in_fill), .inst_en (n_inst)
    );

    // Memory port, driven from the state and the word counter.
    always_comb begin
        mem_req        = (st != ST_IDLE);
        mem_we         = (st == ST_WB) || (st == ST_WR);
        mem_bufferable = (st == ST_WB) || (st == ST_WR && lat_b);
        mem_wdata      = lat_wdata;
        mem_addr       = {lat_word, 2'b00};
        if (st == ST_WB) begin
            mem_addr  = {((lat_tgt == TGT_MAIN) ? m_vl : n_vl), cnt, 2'b00};
            mem_wdata = (lat_tgt == TGT_MAIN) ? m_rd : n_rd;
        end else if (st == ST_FILL) begin
            mem_addr = {lat_word[ADDR_W-3:OFF_W], cnt, 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            lat_tgt   <= TGT_NONE;
            cnt       <= '0;
            lat_word  <= '0;
            lat_wdata <= '0;
            lat_b     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (accept) begin
                    lat_word  <= req_addr[ADDR_W-1:2];
                    lat_wdata <= req_wdata;
                    lat_b     <= req_bufferable;
                    lat_tgt   <= tgt_now;
                    cnt       <= '0;
                    if (hit_any) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= req_write ? '0 : (hit_main ? m_rd : n_rd);
                    end else if (req_write) begin
                        st <= ST_WR;
                    end else if (tgt_now == TGT_NONE) begin
                        st <= ST_RD;
                    end else if ((tgt_now == TGT_MAIN) ? m_vd : n_vd) begin
                        st <= ST_WB;
                    end else begin
                        st <= ST_FILL;
                    end
                end
                ST_WB: if (mem_ack) begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    if (cnt == lat_word[OFF_W-1:0]) rsp_rdata <= mem_rdata;
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) begin
                        rsp_valid <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_RD: if (mem_ack) begin
                    rsp_rdata <= mem_rdata;
                    rsp_valid <= 1'b1;
                    st        <= ST_IDLE;
                end
                ST_WR: if (mem_ack) begin
                    rsp_rdata <= '0;
                    rsp_valid <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcc_checker.sv
`timescale 1ns/1ps
module dcc_checker #(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               cache_en,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic               req_cacheable,
    input logic               rsp_valid,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input dcc_pkg::dcc_state_e st,
    input logic               hit_any
);
    import dcc_pkg::*;

    logic acc;
    assign acc = req_valid && req_ready;

    assert_hit_resp_R1: assert property (@(posedge clk) disable iff (rst)
        (acc && hit_any) |=> (rsp_valid && !mem_req));

    assert_uncached_read_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && !hit_any && !req_cacheable) |=> (st == ST_RD));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_store_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !hit_any) |=> (st == ST_WR && mem_we));

    assert_wb_then_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB) |=> (st == ST_WB || st == ST_FILL));

    assert_disabled_miss_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && !cache_en) |=> (!rsp_valid && mem_req));

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req));
endmodule

bind dcc_top dcc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cache_en      (cache_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_cacheable (req_cacheable),
    .rsp_valid     (rsp_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .st            (st),
    .hit_any       (hit_any)
);

// File: tb/dcc_top_tb.sv
`timescale 1ns/1ps
module dcc_top_tb;

    typedef struct packed {
        logic        we;
        logic        en;
        logic        c;
        logic        b;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
        logic        wbuf;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,12'h000,32'h0,4'd8,4'd0,1'b0}, // R4 main fill set0 way0
        '{1'b0,1'b1,1'b1,1'b1,12'h004,32'h0,4'd0,4'd0,1'b0}, // R1 hit
        '{1'b0,1'b1,1'b0,1'b0,12'h000,32'h0,4'd0,4'd0,1'b0}, // R1 hit with C=0
        '{1'b0,1'b1,1'b0,1'b0,12'h100,32'h0,4'd1,4'd0,1'b0}, // R2 uncached
        '{1'b0,1'b1,1'b0,1'b1,12'h100,32'h0,4'd1,4'd0,1'b0}, // R2 again, not allocated
        '{1'b0,1'b1,1'b1,1'b0,12'h020,32'h0,4'd8,4'd0,1'b0}, // R3 mini fill set1 way0
        '{1'b0,1'b1,1'b1,1'b1,12'h024,32'h0,4'd0,4'd0,1'b0}, // R3 mini hit with B=1
        '{1'b1,1'b1,1'b0,1'b0,12'h008,32'h1111_AAAA,4'd0,4'd0,1'b0}, // R7 store hit main
        '{1'b0,1'b1,1'b1,1'b1,12'h008,32'h0,4'd0,4'd0,1'b0}, // R7 read back
        '{1'b1,1'b1,1'b1,1'b1,12'h024,32'h2222_BBBB,4'd0,4'd0,1'b0}, // R7 store hit mini
        '{1'b1,1'b1,1'b1,1'b1,12'h200,32'h3333_CCCC,4'd0,4'd1,1'b1}, // R8 store miss B=1
        '{1'b0,1'b1,1'b0,1'b0,12'h200,32'h0,4'd1,4'd0,1'b0}, // R8 not allocated
        '{1'b1,1'b1,1'b0,1'b0,12'h204,32'h4444_DDDD,4'd0,4'd1,1'b0}, // R8 store miss B=0
        '{1'b0,1'b1,1'b1,1'b1,12'h080,32'h0,4'd8,4'd0,1'b0}, // R6 set0 way1
        '{1'b0,1'b0,1'b1,1'b1,12'h080,32'h0,4'd1,4'd0,1'b0}, // R10 disabled load
        '{1'b1,1'b0,1'b1,1'b1,12'h300,32'h5555_EEEE,4'd0,4'd1,1'b1}, // R10 disabled store
        '{1'b0,1'b1,1'b1,1'b1,12'h084,32'h0,4'd0,4'd0,1'b0}, // R1 hit after re-enable
        '{1'b0,1'b1,1'b1,1'b1,12'h180,32'h0,4'd8,4'd8,1'b1}, // R9 evict dirty 0x000
        '{1'b0,1'b1,1'b0,1'b0,12'h008,32'h0,4'd1,4'd0,1'b0}, // R9 evicted data in memory
        '{1'b0,1'b1,1'b1,1'b0,12'h060,32'h0,4'd8,4'd0,1'b0}, // R6 mini set1 way1
        '{1'b0,1'b1,1'b1,1'b0,12'h0E0,32'h0,4'd8,4'd8,1'b1}, // R6 wrap, evict dirty 0x020
        '{1'b0,1'b1,1'b0,1'b0,12'h024,32'h0,4'd1,4'd0,1'b0}, // R9 mini data in memory
        '{1'b0,1'b1,1'b1,1'b1,12'h0A0,32'h0,4'd8,4'd0,1'b0}, // R6 main set1 way0
        '{1'b1,1'b1,1'b1,1'b0,12'h0A4,32'h6666_0F0F,4'd0,4'd0,1'b0}, // R7 dirty set1
        '{1'b0,1'b1,1'b1,1'b1,12'h1A0,32'h0,4'd8,4'd0,1'b0}, // R6 set1 way1
        '{1'b0,1'b1,1'b1,1'b1,12'h2A0,32'h0,4'd8,4'd8,1'b1}, // R6 set1 wraps to dirty way0
        '{1'b0,1'b1,1'b0,1'b0,12'h0A4,32'h0,4'd1,4'd0,1'b0}, // R9 written-back word
        '{1'b0,1'b1,1'b0,1'b1,12'h180,32'h0,4'd0,4'd0,1'b0}  // R1 hit set0 way0
    };
    string vreq [NV] = '{"R4","R1","R1","R2","R2","R3","R3","R7","R7","R7",
                         "R8","R8","R8","R6","R10","R10","R1","R9","R9","R6",
                         "R6","R9","R6","R7","R6","R6","R9","R1"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_cacheable = 1'b0;
    logic        req_bufferable = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we, mem_bufferable;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk; // 250 MHz

    dcc_top u_dut (
        .clk (clk), .rst (rst), .cache_en (cache_en),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_cacheable (req_cacheable), .req_bufferable (req_bufferable),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_bufferable (mem_bufferable), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    logic [31:0] memm [1024];
    logic [31:0] gold [1024];
    logic [31:0] rd_log [16];
    int nrd, nwr, buf_bad, wr_after_rd;
    logic exp_buf;
    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle acknowledge per held request.
    initial begin
        for (int i = 0; i < 1024; i++) begin
            memm[i] = {16'hC0DE, 16'(i)};
            gold[i] = {16'hC0DE, 16'(i)};
        end
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_ack = 1'b0;
            end else if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    memm[mem_addr[11:2]] = mem_wdata;
                    if (nrd > 0) wr_after_rd++;
                    if (mem_bufferable !== exp_buf) buf_bad++;
                    nwr++;
                end else begin
                    mem_rdata = memm[mem_addr[11:2]];
                    if (nrd < 16) rd_log[nrd] = mem_addr;
                    nrd++;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic do_access(input vec_t v, output logic [31:0] got, output int lat);
        @(negedge clk);
        nrd = 0; nwr = 0; buf_bad = 0; wr_after_rd = 0; exp_buf = v.wbuf;
        cache_en = v.en; req_write = v.we; req_addr = {20'h0, v.addr};
        req_wdata = v.data; req_cacheable = v.c; req_bufferable = v.b;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        got = rsp_rdata;
    endtask

    task automatic check_vec(input vec_t v, input string rq);
        logic [31:0] got;
        int lat;
        do_access(v, got, lat);
        chk(lat < 400, rq, "response arrived", 32'(lat), 32'd0);
        if (v.we) gold[v.addr[11:2]] = v.data;
        else chk(got == gold[v.addr[11:2]], rq, "load data", got, gold[v.addr[11:2]]);
        chk(nrd == int'(v.nrd), rq, "memory reads", 32'(nrd), 32'(v.nrd));
        chk(nwr == int'(v.nwr), rq, "memory writes", 32'(nwr), 32'(v.nwr));
        if (v.nwr != 0) chk(buf_bad == 0, rq, "bufferable mismatches", 32'(buf_bad), 32'd0);
        if (v.nrd == 8 && v.nwr == 8)
            chk(wr_after_rd == 0, "R9", "writes after first fill read", 32'(wr_after_rd), 32'd0);
        if (v.nrd == 8) begin
            for (int k = 0; k < 8; k++)
                chk(rd_log[k] == {20'h0, v.addr[11:5], 5'(k * 4)}, "R5", "fill address",
                    rd_log[k], {20'h0, v.addr[11:5], 5'(k * 4)});
        end
        if (v.nrd == 0 && v.nwr == 0)
            chk(lat == 1, "R1", "hit latency", 32'(lat), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_t rv;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "req_ready in reset", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0, "R11", "mem_req in reset", 32'(mem_req), 32'd0);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) check_vec(VECS[i], vreq[i]);

        // R11: reset invalidates every line, so a resident line misses again.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R11", "idle after reset",
            {30'd0, req_ready, mem_req}, 32'd2);
        rst = 1'b0;
        rv = '{1'b0,1'b1,1'b1,1'b1,12'h184,32'h0,4'd8,4'd0,1'b0};
        check_vec(rv, "R11");
        // R6: after reset the set0 pointer restarts at way 0; second alloc lands in way 1.
        rv = '{1'b0,1'b1,1'b1,1'b1,12'h080,32'h0,4'd8,4'd0,1'b0};
        check_vec(rv, "R6");
        rv = '{1'b0,1'b1,1'b1,1'b0,12'h184,32'h0,4'd0,4'd0,1'b0};
        check_vec(rv, "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule